// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, clock by clock, when the gate of a synchronous-rectifier switch is driven. It watches three digitised comparator flags taken across the switch's drain and source: a turn-on flag, high while the body diode conducts (drain-source below roughly -100 mV); a turn-off flag, high once the drain-source voltage climbs above a threshold a few millivolts under zero; and a reset flag, high while the drain-source voltage is above about +2 V. It also takes an external direct-turn-off input, called sync here. All four inputs are asynchronous to the clock and pass through two-flop synchronisers before any logic uses them.

The block rejects comparator ringing on both sides of a conduction interval. When the gate turns on, a minimum-on window of `mot_cycles` clock cycles starts, and the turn-off flag is ignored until it ends. When the gate turns off, a blanking window of `blank_cycles` cycles starts, and the turn-on flag is ignored during it. Blanking ends early when the reset flag has been qualified or when sync rises. While sync is high it forces the gate low at once, even inside the minimum-on window. The reset flag also ends a gate pulse early. From power-up the gate stays disabled until the first qualified reset flag or the first sync rising edge, so the first pulse is never started part way through a switching cycle.

Top module: `sr_gate_seq`

## Requirements
- R1: After reset `gate_on` is 0. It stays 0 even when the turn-on flag is held high, until a qualified reset flag or a sync rising edge has armed the block.
- R2: When the block is armed and sync is low, `gate_on` goes high on the third rising clock edge after `on_flag_raw` rises. There are two synchroniser stages and one state register.
- R3: While the gate is on, the turn-off flag is ignored for the minimum-on window. If `off_flag_raw` is raised `a` cycles after the first cycle with the gate high (a >= 0), the gate stays high for max(a+3, mot_cycles+1) cycles. With the turn-off flag already high, the pulse lasts exactly mot_cycles+1 cycles.
- R4: Once the minimum-on window has expired, a synchronised turn-off flag ends the pulse and starts blanking.
- R5: During blanking the turn-on flag is ignored. If the turn-on flag is held high across a turn-off caused by the turn-off flag, the gate stays low for exactly blank_cycles+2 cycles before the next pulse.
- R6: A qualified reset flag during blanking ends the blanking window at once, so a new turn-on is accepted long before `blank_cycles` expires.
- R7: The reset flag is qualified only after it has stayed high, once synchronised, for QUAL_CYC consecutive cycles. A shorter pulse has no effect and does not arm the block.
- R8: While sync is high, `gate_on` is 0 from the second rising edge after `sync_raw` rises. This override holds even inside the minimum-on window.
- R9: A sync rising edge clears both timers and returns the block to the armed state, with no blanking. Once sync falls, a held turn-on flag turns the gate on again on the third edge after `sync_raw` falls. A sync level that stays high does not clear the timers a second time.
- R10: A qualified reset flag while the gate is on ends the pulse, even inside the minimum-on window.
- R11: `mot_cycles` and `blank_cycles` are taken only while the gate is low. A change made while the gate is high does not alter the running pulse or the blanking window that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_flag_raw | input | 1 | Turn-on comparator flag (1 = body-diode conduction), asynchronous |
| off_flag_raw | input | 1 | Turn-off comparator flag (1 = drain-source above turn-off threshold), asynchronous |
| rst_flag_raw | input | 1 | Reset comparator flag (1 = drain-source above positive threshold), asynchronous |
| sync_raw | input | 1 | External direct turn-off, 1 = force gate low, asynchronous |
| mot_cycles | input | MOT_W | Minimum-on window length in clock cycles |
| blank_cycles | input | BLK_W | Blanking window length in clock cycles |
| gate_on | output | 1 | Gate enable for the rectifier switch driver |

## Verification
Two functions can act in the same cycle: the sync override, which forces the gate low, and the minimum-on window, which holds the gate high. The bench provokes this by raising sync a few cycles into a 50-cycle window. It then requires the gate low exactly two edges later, far inside the window. A second collision arises when a blanking window meets a sync rising edge or a qualified reset flag while the turn-on flag is still held. Here the gate must turn on again within a handful of cycles rather than after the programmed blanking length. Each collision is judged by its exact edge count or by a bound set well below the window it cuts short.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_ARMED = 3'd1,
    ST_MASK  = 3'd2,
    ST_COND  = 3'd3,
    ST_BLANK = 3'd4
  } sr_state_e;

  // index of each flag inside the synchroniser bank
  localparam int FLG_ON   = 0;
  localparam int FLG_OFF  = 1;
  localparam int FLG_RST  = 2;
  localparam int FLG_SYNC = 3;
  localparam int FLG_N    = 4;

  function automatic logic drives_gate(input sr_state_e st);
    return (st == ST_MASK) || (st == ST_COND);
  endfunction

  // cycles the gate stays high when the turn-off flag is already present
  function automatic int unsigned hold_len(input int unsigned mot);
    return mot + 1;
  endfunction

endpackage

// File: rtl/sr_sync_bank.sv
module sr_sync_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= '0;
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end

endmodule

// File: rtl/sr_rst_qual.sv
module sr_rst_qual #(
  parameter int QUAL_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  output logic ok
);

  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run <= '0;
    else if (!flag)      run <= '0;
    else if (run != LIMIT) run <= run + 1'b1;
  end

  assign ok = (run == LIMIT);

endmodule

// File: rtl/sr_edge_det.sv
module sr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= d;
  end

  assign rise = d & ~prev;

endmodule

// File: rtl/sr_gate_fsm.sv
module sr_gate_fsm
  import sr_seq_pkg::*;
#(
  parameter int MOT_W = 8,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_on,
  input  logic             s_off,
  input  logic             s_sync,
  input  logic             sync_rise,
  input  logic             rst_ok,
  input  logic [MOT_W-1:0] mot_cycles,
  input  logic [BLK_W-1:0] blank_cycles,
  output logic             gate_on,
  output logic             armed,
  output logic             blanking
);

  localparam int TMR_W = (MOT_W > BLK_W) ? MOT_W : BLK_W;

  sr_state_e        state, state_nxt;
  logic [TMR_W-1:0] tmr, tmr_nxt;
  logic [BLK_W-1:0] blk_lat;
  logic             tmr_zero;

  assign tmr_zero = (tmr == '0);

  always_comb begin
    state_nxt = state;
    tmr_nxt   = tmr;
    unique case (state)
      ST_INIT: begin
        if (sync_rise || rst_ok) state_nxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (s_on && !s_sync) begin
          state_nxt = ST_MASK;
          tmr_nxt   = TMR_W'(mot_cycles);
        end
      end
      ST_MASK: begin
        if (s_sync || rst_ok) begin
          state_nxt = ST_ARMED;
          tmr_nxt   = '0;
        end else if (tmr_zero) begin
          if (s_off) begin
            state_nxt = ST_BLANK;
            tmr_nxt   = TMR_W'(blk_lat);
          end else begin
            state_nxt = ST_COND;
          end
        end else begin
          tmr_nxt = tmr - 1'b1;
        end
      end
      ST_COND: begin
        if (s_sync || rst_ok) begin
          state_nxt = ST_ARMED;
        end else if (s_off) begin
          state_nxt = ST_BLANK;
          tmr_nxt   = TMR_W'(blk_lat);
        end
      end
      ST_BLANK: begin
        if (sync_rise || rst_ok || tmr_zero) begin
          state_nxt = ST_ARMED;
          tmr_nxt   = '0;
        end else begin
          tmr_nxt = tmr - 1'b1;
        end
      end
      default: state_nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_INIT;
      tmr     <= '0;
      blk_lat <= '0;
    end else begin
      state <= state_nxt;
      tmr   <= tmr_nxt;
      if (!drives_gate(state)) blk_lat <= blank_cycles;
    end
  end

  assign gate_on  = drives_gate(state) & ~s_sync;
  assign armed    = (state == ST_ARMED);
  assign blanking = (state == ST_BLANK);

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_seq_pkg::*;
#(
  parameter int MOT_W    = 8,
  parameter int BLK_W    = 12,
  parameter int QUAL_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_flag_raw,
  input  logic             off_flag_raw,
  input  logic             rst_flag_raw,
  input  logic             sync_raw,
  input  logic [MOT_W-1:0] mot_cycles,
  input  logic [BLK_W-1:0] blank_cycles,
  output logic             gate_on
);

  logic [FLG_N-1:0] raw_flags, s_flags;
  logic s_on, s_off, s_rst, s_sync;
  logic sync_rise, rst_ok, armed, blanking;

  always_comb begin
    raw_flags           = '0;
    raw_flags[FLG_ON]   = on_flag_raw;
    raw_flags[FLG_OFF]  = off_flag_raw;
    raw_flags[FLG_RST]  = rst_flag_raw;
    raw_flags[FLG_SYNC] = sync_raw;
  end

  sr_sync_bank #(.N(FLG_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_flags), .q(s_flags)
  );

  assign s_on   = s_flags[FLG_ON];
  assign s_off  = s_flags[FLG_OFF];
  assign s_rst  = s_flags[FLG_RST];
  assign s_sync = s_flags[FLG_SYNC];

  sr_edge_det u_sync_edge (
    .clk(clk), .rst_n(rst_n), .d(s_sync), .rise(sync_rise)
  );

  sr_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .flag(s_rst), .ok(rst_ok)
  );

  sr_gate_fsm #(.MOT_W(MOT_W), .BLK_W(BLK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .s_on(s_on), .s_off(s_off), .s_sync(s_sync),
    .sync_rise(sync_rise), .rst_ok(rst_ok),
    .mot_cycles(mot_cycles), .blank_cycles(blank_cycles),
    .gate_on(gate_on), .armed(armed), .blanking(blanking)
  );

endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk #(
  parameter int MOT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_raw,
  input logic [MOT_W-1:0] mot_cycles,
  input logic             gate_on,
  input logic             s_on,
  input logic             s_sync,
  input logic             sync_rise,
  input logic             rst_ok,
  input logic             armed,
  input logic             blanking
);

  logic [15:0]      hi_len;
  logic [MOT_W-1:0] chk_mot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len  <= '0;
      chk_mot <= '0;
    end else begin
      if (gate_on) hi_len <= (hi_len == 16'hffff) ? hi_len : hi_len + 1'b1;
      else         hi_len <= '0;
      if (!gate_on) chk_mot <= mot_cycles;
    end
  end

  AST_SYNC_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_raw |-> ##2 !gate_on); // R8

  AST_TURNON_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(s_on)); // R2

  AST_TURNON_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(armed)); // R1

  AST_MOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_on) && !s_sync && !$past(s_sync) && !$past(rst_ok))
      |-> (hi_len >= 16'(chk_mot) + 16'd1)); // R3

  AST_SYNC_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (!blanking && !gate_on)); // R9

  AST_RST_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && gate_on) |=> !gate_on); // R10

  AST_RST_ENDS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && blanking) |=> !blanking); // R6

endmodule

bind sr_gate_seq sr_gate_seq_chk #(.MOT_W(MOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_raw(sync_raw), .mot_cycles(mot_cycles),
  .gate_on(gate_on), .s_on(s_on), .s_sync(s_sync), .sync_rise(sync_rise),
  .rst_ok(rst_ok), .armed(armed), .blanking(blanking)
);

// File: tb/sr_gate_seq_bench.sv
module sr_gate_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MOT_W = 8;
  localparam int BLK_W = 12;
  localparam int QUAL  = 20;

  // {mot_cycles, blank_cycles, off-flag delay a}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 0}, '{5, 3, 0}, '{5, 3, 10}, '{12, 7, 2}, '{1, 20, 6}, '{30, 1, 30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_r = 1'b0, off_r = 1'b0, rst_r = 1'b0, sync_r = 1'b0;
  logic [MOT_W-1:0] mot = '0;
  logic [BLK_W-1:0] blk = '0;
  logic gate;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_gate_seq #(.MOT_W(MOT_W), .BLK_W(BLK_W), .QUAL_CYC(QUAL)) u_sr_gate_seq (
    .clk(clk), .rst_n(rst_n), .on_flag_raw(on_r), .off_flag_raw(off_r),
    .rst_flag_raw(rst_r), .sync_raw(sync_r), .mot_cycles(mot),
    .blank_cycles(blk), .gate_on(gate)
  );

  function automatic int exp_len(input int m, input int a);
    return (a + 3 > m + 1) ? a + 3 : m + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // ticks until gate == lvl; n = ticks taken, -1 on timeout
  task automatic wait_gate(input logic lvl, input int lim, output int n);
    n = 0;
    while (gate !== lvl) begin
      if (n >= lim) begin n = -1; return; end
      tick(); n++;
    end
  endtask

  // counts negedges with gate at its current level, including the current one
  task automatic run_len(input int lim, output int n);
    logic lvl;
    lvl = gate;
    n = 1;
    forever begin
      tick();
      if (gate !== lvl || n >= lim) return;
      n++;
    end
  endtask

  task automatic settle(input int n);
    on_r = 0; off_r = 0; rst_r = 0; sync_r = 0;
    repeat (n) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int n, idx, len;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: reset state and no activation before arming
    check(gate === 1'b0, "R1 reset", gate, 0);
    on_r = 1;
    n = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (gate) n++; end
    check(n == 0, "R1 unarmed", n, 0);
    on_r = 0; tick(); tick(); tick();

    // R7: short reset flag does not arm
    rst_r = 1; repeat (QUAL - 1) tick(); rst_r = 0;
    repeat (5) tick();
    on_r = 1;
    n = 0;
    for (int i = 0; i < 15; i++) begin tick(); if (gate) n++; end
    check(n == 0, "R7 short", n, 0);
    on_r = 0; repeat (4) tick();
    rst_r = 1; repeat (QUAL + 2) tick(); rst_r = 0;
    repeat (6) tick();
    mot = 2; blk = 3;
    on_r = 1;
    // R2: third edge after the raw turn-on flag
    tick(); check(gate === 1'b0, "R2 edge2", gate, 0);
    tick(); check(gate === 1'b0, "R2 edge2", gate, 0);
    tick(); check(gate === 1'b1, "R7 armed R2 edge3", gate, 1);
    off_r = 1; on_r = 0;
    wait_gate(1'b0, 20, n);
    settle(20);

    // vector table: R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      int m, b, a, g, l2;
      m = VEC[v][0]; b = VEC[v][1]; a = VEC[v][2];
      mot = MOT_W'(m); blk = BLK_W'(b);
      tick();
      on_r = 1;
      wait_gate(1'b1, 10, n);
      idx = 0;
      forever begin
        if (idx == a) off_r = 1;
        tick(); idx++;
        if (!gate || idx > 500) break;
      end
      len = idx;
      check(len == exp_len(m, a), "R3 R4 pulse", len, exp_len(m, a));
      run_len(500, g);
      check(g == b + 2, "R5 blank gap", g, b + 2);
      run_len(500, l2);
      check(l2 == m + 1, "R3 held-off pulse", l2, m + 1);
      on_r = 0;
      repeat (m + 4) tick();
      settle(b + 10);
    end

    // R11: timer inputs changed while gate is high
    mot = 10; blk = 4; tick();
    off_r = 1; on_r = 1;
    wait_gate(1'b1, 10, n);
    mot = 60; blk = 200;
    run_len(500, len);
    check(len == 11, "R11 mot kept", len, 11);
    run_len(500, n);
    check(n == 6, "R11 blank kept", n, 6);
    on_r = 0; repeat (70) tick();
    settle(210);

    // R8: sync inside the minimum-on window
    mot = 50; blk = 100; tick();
    on_r = 1;
    wait_gate(1'b1, 10, n);
    tick(); tick();
    sync_r = 1;
    tick(); check(gate === 1'b1, "R8 edge1", gate, 1);
    tick(); check(gate === 1'b0, "R8 override", gate, 0);
    tick(); tick();
    // R9: sync falling, armed without blanking
    sync_r = 0;
    tick(); tick(); check(gate === 1'b0, "R9 edge2", gate, 0);
    tick(); check(gate === 1'b1, "R9 rearm", gate, 1);
    off_r = 1;
    wait_gate(1'b0, 100, n);
    check(n > 0, "R4 off after mot", n, 1);
    // in blanking of 100; sync pulse clears it
    repeat (5) tick();
    sync_r = 1; tick(); tick(); sync_r = 0;
    wait_gate(1'b1, 10, n);
    check(n >= 0, "R9 blank cleared", n, 5);
    // pulse of 51 then blanking 100; reset flag cuts it short
    wait_gate(1'b0, 100, n);
    repeat (3) tick();
    rst_r = 1; repeat (QUAL + 1) tick(); rst_r = 0;
    wait_gate(1'b1, 10, n);
    check(n >= 0, "R6 rst ends blank", n, 3);
    // R10: reset flag during minimum-on window
    tick();
    on_r = 0; rst_r = 1;
    n = 0;
    for (int i = 0; i < QUAL + 8; i++) begin tick(); if (gate) n++; end
    check(gate === 1'b0, "R10 pulse cut", gate, 0);
    check(n < 45, "R10 before mot", n, QUAL + 4);
    settle(150);
    check(gate === 1'b0, "R10 stays low", gate, 0);
    finish_run();
  end

endmodule